// File: doc/BRIEF.md
# Multilevel Channel Level Calibrator

This block sits on the tester side of a test channel that carries four bits per clock as one of sixteen voltage levels. An 8-bit DAC sets the level, and a 4-bit ADC on the receiving side decodes it. Because the converters are not linear, a straight scaling of the symbol to a DAC code puts some levels near bin boundaries. The block learns better codes in two phases.

In the calibration phase, a pulse on `cal_start` makes the block sweep the DAC code upward from 0 to 255. It holds each code for a programmable settle interval and reads the ADC result that comes back. Each time the returned bin moves up by exactly one, the block notes the ramp code as the lower edge of that bin. When a second edge is known, it stores the midpoint between the two edges as the drive code for the symbol between them. Fourteen such codes are kept, one for each symbol from 1 to 14. Symbols 0 and 15 are pinned to the ends of the DAC range.

In the transmit phase, symbols arrive on a valid/ready stream. Each accepted symbol sets the DAC code that is driven from the next cycle on, so the channel can move one symbol per clock. Ready is held low while a sweep runs, and also until a sweep has ended cleanly. A producer must keep `sym_data` steady while `sym_valid` is high and `sym_ready` is low. No symbol is taken in a cycle where ready is low.

Top module: `mvl_cal_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, `cal_done` and `cal_err` are 0, and `sym_ready` is 0.
- R2: A `cal_start` pulse starts a sweep in which `dac_code` holds each value for S cycles, where S = max(`settle_cycles`, 2). The value steps by exactly +1 from 0 to 255, and the sweep lasts 256·S cycles from the start edge. A pulse during a sweep restarts it from 0.
- R3: After the ADC sample taken at code 255, `cal_done` rises if the sampled bins climbed 0→1→…→15 with no gap. `cal_done` and `cal_err` are never both high, and `sym_ready` is high whenever `cal_done` is high and no sweep runs.
- R4: Let E_k be the first ramp code whose sampled ADC code is k. For symbols k = 1..14, the transmit code is floor((E_k + E_(k+1)) / 2).
- R5: Symbol 0 drives DAC code 0, and symbol 15 drives DAC code 255.
- R6: The sweep ends with `cal_err` = 1 and `cal_done` = 0 in two cases: a sample jumps up by more than one bin, or bin 15 is never reached. While `cal_err` is high, `sym_ready` is low and offered symbols leave `dac_code` unchanged.
- R7: A sampled ADC code equal to or below the current bin changes nothing, so a downward glitch leaves the learned codes intact.
- R8: A symbol is taken on a cycle with `sym_valid` and `sym_ready` both high. Its code appears on `dac_code` in the next cycle and holds until the next accepted symbol. `sym_ready` is low during a sweep.
- R9: A `settle_cycles` value of 0 or 1 behaves as 2.
- R10: A new `cal_start` clears `cal_done` and `cal_err` and recalibrates, including after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cal_start | input | 1 | One-cycle pulse that begins a sweep |
| settle_cycles | input | 8 | Cycles spent on each ramp code (minimum 2) |
| adc_code | input | 4 | Bin reported by the receiving ADC |
| cal_done | output | 1 | Last sweep finished with all 15 edges found |
| cal_err | output | 1 | Last sweep found a skipped or missing bin |
| sym_valid | input | 1 | Symbol stream valid |
| sym_ready | output | 1 | Symbol stream ready |
| sym_data | input | 4 | Symbol to transmit |
| dac_code | output | 8 | Code driven to the channel DAC |

## Verification
The assertions assume that `cal_start` arrives as single-cycle pulses. They also assume the ADC result settles within one cycle of a DAC change, which the two-cycle minimum settle covers. The bench feeds `adc_code` from a registered threshold model of the DAC code, so that latency is always met. Threshold sets come from `$urandom` as strictly rising edges, plus a linear set with edges at codes 0 and 255. Directed sets with a doubled threshold or an unreachable top bin drive the error path. The glitch model lowers the code only away from any threshold, so the learned edges stay predictable.

// File: rtl/mvl_cal_pkg.sv
package mvl_cal_pkg;
  // smallest settle interval that hides one cycle of ADC latency
  localparam int unsigned MIN_SETTLE = 2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RAMP = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mvl_ramp_seq.sv
module mvl_ramp_seq
  import mvl_cal_pkg::*;
#(
  parameter int DAC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] settle,
  output logic             busy,
  output logic [DAC_W-1:0] ramp,
  output logic             smp,
  output logic             last
);
  localparam logic [DAC_W-1:0] RAMP_TOP = {DAC_W{1'b1}};
  localparam logic [CNT_W-1:0] SETTLE_LO = CNT_W'(MIN_SETTLE);

  seq_state_e       state;
  logic [CNT_W-1:0] dwell;
  logic [CNT_W-1:0] limit;

  assign busy = (state == SEQ_RAMP);
  assign smp  = busy && (dwell == limit - 1'b1);
  assign last = smp && (ramp == RAMP_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      ramp  <= '0;
      dwell <= '0;
      limit <= SETTLE_LO;
    end else if (start) begin
      state <= SEQ_RAMP;
      ramp  <= '0;
      dwell <= '0;
      limit <= (settle < SETTLE_LO) ? SETTLE_LO : settle;
    end else if (busy) begin
      if (smp) begin
        dwell <= '0;
        if (ramp == RAMP_TOP) state <= SEQ_IDLE;
        else                  ramp  <= ramp + 1'b1;
      end else begin
        dwell <= dwell + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mvl_edge_bank.sv
module mvl_edge_bank #(
  parameter int SYM_W = 4,
  parameter int DAC_W = 8,
  localparam int NMID = (1 << SYM_W) - 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       smp,
  input  logic                       last,
  input  logic [DAC_W-1:0]           ramp,
  input  logic [SYM_W-1:0]           adc,
  output logic [NMID-1:0][DAC_W-1:0] lvl,
  output logic                       done,
  output logic                       err
);
  localparam logic [SYM_W-1:0] TOP_BIN = {SYM_W{1'b1}};

  logic [SYM_W-1:0] cur_bin;
  logic [DAC_W-1:0] edge_prev;
  logic             skip;

  logic [SYM_W:0]   up_bin;
  logic             step;
  logic             jump;
  logic [SYM_W-1:0] nxt_bin;
  logic             nxt_skip;
  logic             wr_en;
  logic [SYM_W-1:0] wr_idx;
  logic [DAC_W:0]   pair_sum;
  logic [DAC_W-1:0] mid;

  always_comb begin
    up_bin   = {1'b0, cur_bin} + 1'b1;
    step     = smp && ({1'b0, adc} == up_bin);
    jump     = smp && ({1'b0, adc} >  up_bin);
    nxt_bin  = step ? adc : cur_bin;
    nxt_skip = skip | jump;
    wr_en    = step && (cur_bin != '0);
    wr_idx   = cur_bin - 1'b1;
    pair_sum = {1'b0, edge_prev} + {1'b0, ramp};
    mid      = pair_sum[DAC_W:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bin   <= '0;
      edge_prev <= '0;
      skip      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else if (start) begin
      cur_bin   <= '0;
      edge_prev <= '0;
      skip      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      cur_bin <= nxt_bin;
      skip    <= nxt_skip;
      if (step) edge_prev <= ramp;
      if (last) begin
        done <= !nxt_skip && (nxt_bin == TOP_BIN);
        err  <=  nxt_skip || (nxt_bin != TOP_BIN);
      end
    end
  end

  for (genvar i = 0; i < NMID; i++) begin : g_lvl
    logic [DAC_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                code_q <= '0;
      else if (wr_en && (wr_idx == SYM_W'(i)))   code_q <= mid;
    end
    assign lvl[i] = code_q;
  end
endmodule

// File: rtl/mvl_sym_map.sv
module mvl_sym_map #(
  parameter int SYM_W = 4,
  parameter int DAC_W = 8,
  localparam int NMID = (1 << SYM_W) - 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_en,
  input  logic                       sym_valid,
  input  logic [SYM_W-1:0]           sym_data,
  input  logic [NMID-1:0][DAC_W-1:0] lvl,
  output logic                       sym_ready,
  output logic [DAC_W-1:0]           tx_code
);
  logic [DAC_W-1:0] map_code;
  logic [SYM_W-1:0] sel;

  assign sym_ready = tx_en;
  assign sel       = sym_data - 1'b1;

  always_comb begin
    if (sym_data == '0)                 map_code = '0;
    else if (sym_data == {SYM_W{1'b1}}) map_code = {DAC_W{1'b1}};
    else                                map_code = lvl[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tx_code <= '0;
    else if (sym_valid && sym_ready) tx_code <= map_code;
  end
endmodule

// File: rtl/mvl_cal_ctrl.sv
module mvl_cal_ctrl #(
  parameter int SYM_W = 4,
  parameter int DAC_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic [SYM_W-1:0] adc_code,
  output logic             cal_done,
  output logic             cal_err,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_data,
  output logic [DAC_W-1:0] dac_code
);
  localparam int NMID = (1 << SYM_W) - 2;

  logic                       busy;
  logic [DAC_W-1:0]           ramp;
  logic                       smp;
  logic                       last;
  logic [NMID-1:0][DAC_W-1:0] lvl;
  logic [DAC_W-1:0]           tx_code;

  mvl_ramp_seq #(.DAC_W(DAC_W), .CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cal_start),
    .settle (settle_cycles),
    .busy   (busy),
    .ramp   (ramp),
    .smp    (smp),
    .last   (last)
  );

  mvl_edge_bank #(.SYM_W(SYM_W), .DAC_W(DAC_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cal_start),
    .smp   (smp),
    .last  (last),
    .ramp  (ramp),
    .adc   (adc_code),
    .lvl   (lvl),
    .done  (cal_done),
    .err   (cal_err)
  );

  mvl_sym_map #(.SYM_W(SYM_W), .DAC_W(DAC_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (cal_done && !busy),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .lvl       (lvl),
    .sym_ready (sym_ready),
    .tx_code   (tx_code)
  );

  assign dac_code = busy ? ramp : tx_code;
endmodule

// File: rtl/mvl_cal_ctrl_chk.sv
module mvl_cal_ctrl_chk #(
  parameter int SYM_W = 4,
  parameter int DAC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cal_busy,
  input logic             cal_start,
  input logic             cal_done,
  input logic             cal_err,
  input logic             sym_valid,
  input logic             sym_ready,
  input logic [SYM_W-1:0] sym_data,
  input logic [DAC_W-1:0] dac_code
);
  localparam logic [DAC_W-1:0] ONE  = DAC_W'(1);
  localparam logic [DAC_W-1:0] FULL = {DAC_W{1'b1}};
  localparam logic [SYM_W-1:0] SMAX = {SYM_W{1'b1}};

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && $past(cal_busy) && !$past(cal_start) && (dac_code != $past(dac_code)))
      |-> (dac_code == $past(dac_code) + ONE));

  // R8
  busy_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> !sym_ready);

  // R3
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_done && cal_err));

  // R3
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !cal_busy) |-> sym_ready);

  // R6
  err_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |-> !sym_ready);

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && !$past(cal_busy) && !$past(sym_valid && sym_ready)) |-> $stable(dac_code));

  // R5
  sym_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && $past(sym_valid && sym_ready && (sym_data == '0))) |-> (dac_code == '0));

  // R5
  sym_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && $past(sym_valid && sym_ready && (sym_data == SMAX))) |-> (dac_code == FULL));
endmodule

bind mvl_cal_ctrl mvl_cal_ctrl_chk #(.SYM_W(SYM_W), .DAC_W(DAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cal_busy  (busy),
  .cal_start (cal_start),
  .cal_done  (cal_done),
  .cal_err   (cal_err),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready),
  .sym_data  (sym_data),
  .dac_code  (dac_code)
);

// File: tb/mvl_cal_ctrl_tb.sv
module mvl_cal_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_start = 1'b0;
  logic [7:0] settle_cycles = 8'd2;
  logic [3:0] adc_code = 4'd0;
  logic       cal_done;
  logic       cal_err;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [3:0] sym_data = 4'd0;
  logic [7:0] dac_code;

  int checks = 0;
  int errors = 0;
  int th[16];
  bit glitch = 1'b0;

  always #5 clk = ~clk;

  mvl_cal_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .settle_cycles(settle_cycles),
    .adc_code(adc_code), .cal_done(cal_done), .cal_err(cal_err),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data), .dac_code(dac_code)
  );

  function automatic int adc_model(int d);
    int f = 0;
    bit on_edge = 1'b0;
    for (int k = 1; k < 16; k++) begin
      if (d >= th[k]) f++;
      if (d == th[k]) on_edge = 1'b1;
    end
    if (glitch && (d % 5 == 2) && !on_edge && f > 0) f--;
    return f;
  endfunction

  function automatic int exp_code(int s);
    if (s == 0)  return 0;
    if (s == 15) return 255;
    return (th[s] + th[s + 1]) / 2;
  endfunction

  always @(posedge clk) adc_code <= 4'(adc_model(int'(dac_code)));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rand_th();
    th[1] = 1 + int'($urandom % 16);
    for (int k = 2; k < 16; k++) th[k] = th[k - 1] + 1 + int'($urandom % 16);
  endtask

  task automatic run_cal(int settle_in, int s_eff, bit expect_ok);
    int n = 0, run = 0, prev = -1, bad_step = 0, bad_rdy = 0;
    @(negedge clk);
    settle_cycles = 8'(settle_in);
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    while (!(cal_done || cal_err) && n < 4000) begin
      if (int'(dac_code) == prev) run++;
      else begin
        if (prev >= 0 && (run != s_eff || int'(dac_code) != prev + 1)) bad_step++;
        prev = int'(dac_code);
        run = 1;
      end
      if (sym_ready) bad_rdy++;
      n++;
      @(negedge clk);
    end
    // R2 / R9: dwell per code and total sweep length
    chk(bad_step == 0 && run == s_eff && prev == 255, "R2 dwell/step", bad_step, 0);
    chk(n == 256 * s_eff, "R2 R9 sweep length", n, 256 * s_eff);
    // R8: no ready during sweep
    chk(bad_rdy == 0, "R8 ready during sweep", bad_rdy, 0);
    // R3 / R6: outcome
    chk(cal_done == expect_ok && cal_err == !expect_ok, "R3 R6 outcome",
        int'({cal_done, cal_err}), expect_ok ? 2 : 1);
    chk(sym_ready == expect_ok, "R3 R6 ready after sweep", int'(sym_ready), int'(expect_ok));
  endtask

  task automatic send_sym(int s);
    int gap = int'($urandom % 3);
    for (int g = 0; g < gap; g++) begin
      logic [7:0] held = dac_code;
      @(negedge clk);
      chk(dac_code == held, "R8 hold without handshake", int'(dac_code), int'(held));
    end
    sym_data = 4'(s);
    sym_valid = 1'b1;
    chk(sym_ready == 1'b1, "R8 ready when calibrated", int'(sym_ready), 1);
    @(negedge clk);
    sym_valid = 1'b0;
    if (s == 0 || s == 15)
      chk(int'(dac_code) == exp_code(s), "R5 end symbol code", int'(dac_code), exp_code(s));
    else
      chk(int'(dac_code) == exp_code(s), "R4 midpoint code", int'(dac_code), exp_code(s));
  endtask

  task automatic sweep_syms(int extra);
    for (int s = 0; s < 16; s++) send_sym(s);
    for (int i = 0; i < extra; i++) send_sym(int'($urandom % 16));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd20150511));
    for (int k = 1; k < 16; k++) th[k] = 16 * k;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dac_code == 8'd0, "R1 dac after reset", int'(dac_code), 0);
    chk(cal_done == 1'b0, "R1 done after reset", int'(cal_done), 0);
    chk(cal_err == 1'b0, "R1 err after reset", int'(cal_err), 0);
    chk(sym_ready == 1'b0, "R1 ready after reset", int'(sym_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // random thresholds, settle 3
    rand_th();
    run_cal(3, 3, 1'b1);
    sweep_syms(30);

    // R7 downward glitches, R10 recalibration
    glitch = 1'b1;
    run_cal(4, 4, 1'b1);
    sweep_syms(10);
    glitch = 1'b0;

    // R9 settle below minimum
    rand_th();
    run_cal(0, 2, 1'b1);
    sweep_syms(10);
    run_cal(1, 2, 1'b1);
    sweep_syms(0);

    // corner: edges at code 0 and code 255
    th[1] = 0;
    for (int k = 2; k < 15; k++) th[k] = 17 * k;
    th[15] = 255;
    run_cal(2, 2, 1'b1);
    sweep_syms(5);

    // R6 skipped bin
    held = dac_code;
    th[6] = th[5];
    run_cal(2, 2, 1'b0);
    sym_data = 4'd9;
    sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    @(negedge clk);
    chk(dac_code == held, "R6 symbol ignored after error", int'(dac_code), int'(held));

    // R6 top bin never reached
    rand_th();
    th[15] = 300;
    run_cal(2, 2, 1'b0);

    // R10 recalibration after error
    rand_th();
    run_cal(2, 2, 1'b1);
    sweep_syms(10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule